// File: doc/BRIEF.md
# 8B/10B Line Encoder with Comma Preamble

This block turns one byte per clock into a 10-bit DC-balanced code group for a downstream serializer. A select input marks each byte as an ordinary data character or as a special control character. The block keeps the running disparity of the line and chooses each code group from the column that matches it, following the IEEE 802.3 8B/10B code tables. The output is registered, so a code group appears one clock after its byte is taken.

The block also starts the link. While the synchronous reset is held, it sends the negative-disparity comma continuously. When reset is released, it sends a short preamble of comma code groups that alternate in disparity. During that preamble, and during reset, `inReady` is low, and any byte presented in those cycles is dropped. User characters are taken only on cycles where `inReady` is high. A control character outside the legal special set is sent as its data encoding, and a flag marks that code group.

Top module: `linecode_enc`

## Requirements
- R1: While `rst` is high, each clock loads `codeOut` with 10'h17C, the negative-disparity K28.5 (abcdei=001111, fghj=1010). Code bit a is at bit 0 and j is at bit 9, in the order a,b,c,d,e,i,f,g,h,j. While `rst` is high, `inReady` and `badCtrl` are low.
- R2: After `rst` falls, the next three code groups are 10'h17C, 10'h283 and 10'h17C, starting from negative disparity. `inReady` is low during those cycles, and bytes presented then never reach the output. `inReady` goes high on the cycle after the third group is loaded.
- R3: With `isCtrl` low, the byte is sent as Dx.y, where x = `charIn[4:0]` (bits E..A) and y = `charIn[7:5]` (bits H..F).
- R4: With `isCtrl` high, the twelve legal specials are sent as Kx.y: K28.0 to K28.7, K23.7, K27.7, K29.7 and K30.7.
- R5: Each code group is taken from the column of the current running disparity. Its disparity is 0 or of the opposite sign to that running disparity, and the running disparity is updated after every code group.
- R6: Every code group contains between four and six ones.
- R7: D.x.7 uses the alternate 4-bit group (0111 under negative, 1000 under positive disparity after the 6-bit group) exactly for x = 17, 18, 20 under negative and x = 11, 13, 14 under positive disparity.
- R8: A control byte outside the legal set is sent as its D encoding. `badCtrl` is high for exactly the cycle in which that code group is on `codeOut`.
- R9: A byte taken at a clock edge appears on `codeOut`, and its flag on `badCtrl`, right after that same edge.
- R10: Raising `rst` in the middle of user traffic drops `inReady` in the same cycle, so the presented byte is discarded and the idle comma is loaded. The next release repeats the full preamble, starting again from negative disparity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| charIn | input | 8 | Byte to encode, bit 0 = A |
| isCtrl | input | 1 | 1 = control character, 0 = data |
| codeOut | output | 10 | Registered code group, bit 0 = a, bit 9 = j |
| inReady | output | 1 | High when the byte on `charIn` is taken at the next edge |
| badCtrl | output | 1 | Marks a code group sent for an illegal control byte |

## Verification
Two things can fall in the same cycle: a user character offered on a ready cycle, and the start of reset. The bench provokes this by raising `rst` on the same falling edge at which it presents a fresh data byte while `inReady` is still high. It then checks three things: `inReady` drops at once, the following code group is the idle comma and not that byte, and the next release repeats the exact three-group preamble from negative disparity. The same overlap happens where the preamble ends and the first user byte begins. That boundary is judged by decoding the first user group and confirming it carries the byte offered on the first ready cycle, not the byte held across the preamble.

// File: rtl/linecode_pkg.sv
package linecode_pkg;

  typedef struct packed {
    logic idle;   // load the fixed idle comma, clear disparity
    logic comma;  // send a preamble comma at current disparity
    logic take;   // encode the user byte
  } encStrobe_t;

  localparam logic [9:0] IDLE_CODE  = 10'h17C;
  localparam logic [7:0] COMMA_BYTE = 8'hBC;   // K28.5

  // 6-bit group, negative column, bit 5 = a ... bit 0 = i
  function automatic logic [5:0] sixNeg(input logic [4:0] x);
    case (x)
      5'd0:  sixNeg = 6'b100111;  5'd1:  sixNeg = 6'b011101;
      5'd2:  sixNeg = 6'b101101;  5'd3:  sixNeg = 6'b110001;
      5'd4:  sixNeg = 6'b110101;  5'd5:  sixNeg = 6'b101001;
      5'd6:  sixNeg = 6'b011001;  5'd7:  sixNeg = 6'b111000;
      5'd8:  sixNeg = 6'b111001;  5'd9:  sixNeg = 6'b100101;
      5'd10: sixNeg = 6'b010101;  5'd11: sixNeg = 6'b110100;
      5'd12: sixNeg = 6'b001101;  5'd13: sixNeg = 6'b101100;
      5'd14: sixNeg = 6'b011100;  5'd15: sixNeg = 6'b010111;
      5'd16: sixNeg = 6'b011011;  5'd17: sixNeg = 6'b100011;
      5'd18: sixNeg = 6'b010011;  5'd19: sixNeg = 6'b110010;
      5'd20: sixNeg = 6'b001011;  5'd21: sixNeg = 6'b101010;
      5'd22: sixNeg = 6'b011010;  5'd23: sixNeg = 6'b111010;
      5'd24: sixNeg = 6'b110011;  5'd25: sixNeg = 6'b100110;
      5'd26: sixNeg = 6'b010110;  5'd27: sixNeg = 6'b110110;
      5'd28: sixNeg = 6'b001110;  5'd29: sixNeg = 6'b101110;
      5'd30: sixNeg = 6'b011110;  default: sixNeg = 6'b101011;
    endcase
  endfunction

  // 4-bit group for data, negative column, bit 3 = f ... bit 0 = j
  function automatic logic [3:0] fourNeg(input logic [2:0] y);
    case (y)
      3'd0: fourNeg = 4'b1011;  3'd1: fourNeg = 4'b1001;
      3'd2: fourNeg = 4'b0101;  3'd3: fourNeg = 4'b1100;
      3'd4: fourNeg = 4'b1101;  3'd5: fourNeg = 4'b1010;
      3'd6: fourNeg = 4'b0110;  default: fourNeg = 4'b1110;
    endcase
  endfunction

  // 4-bit group for specials when the 6-bit group left positive disparity
  function automatic logic [3:0] fourCtrlPos(input logic [2:0] y);
    case (y)
      3'd0: fourCtrlPos = 4'b0100;  3'd1: fourCtrlPos = 4'b1001;
      3'd2: fourCtrlPos = 4'b0101;  3'd3: fourCtrlPos = 4'b0011;
      3'd4: fourCtrlPos = 4'b0010;  3'd5: fourCtrlPos = 4'b1010;
      3'd6: fourCtrlPos = 4'b0110;  default: fourCtrlPos = 4'b1000;
    endcase
  endfunction

endpackage

// File: rtl/linecode_ctrl.sv
module linecode_ctrl
  import linecode_pkg::*;
#(
  parameter int PREAMBLE_LEN = 3
) (
  input  logic       clk,
  input  logic       rst,
  output encStrobe_t strobe,
  output logic       inReady
);
  localparam int CNT_W = $clog2(PREAMBLE_LEN + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PREAMBLE_LEN);

  logic [CNT_W-1:0] sentCnt;
  logic             preDone;

  assign preDone = (sentCnt == LAST);

  always_ff @(posedge clk) begin
    if (rst)           sentCnt <= '0;
    else if (!preDone) sentCnt <= sentCnt + 1'b1;
  end

  always_comb begin
    strobe.idle  = rst;
    strobe.comma = !rst && !preDone;
    strobe.take  = !rst && preDone;
  end

  assign inReady = strobe.take;
endmodule

// File: rtl/linecode_datapath.sv
module linecode_datapath
  import linecode_pkg::*;
(
  input  logic       clk,
  input  encStrobe_t strobe,
  input  logic [7:0] charIn,
  input  logic       isCtrl,
  output logic [9:0] codeOut,
  output logic       badCtrl
);
  logic       rdPos;
  logic [7:0] selByte;
  logic       selCtrl;
  logic [4:0] xVal;
  logic [2:0] yVal;
  logic       ctrlOk, isK28, flip6, rd6, useAlt;
  logic [5:0] s6Neg, s6;
  logic [3:0] s4Base, s4;
  logic       rdNext;
  logic [9:0] encCode;

  always_comb begin
    selByte = strobe.comma ? COMMA_BYTE : charIn;
    selCtrl = strobe.comma ? 1'b1 : isCtrl;
    xVal    = selByte[4:0];
    yVal    = selByte[7:5];
    ctrlOk  = selCtrl && ((xVal == 5'd28) ||
              ((yVal == 3'd7) && (xVal == 5'd23 || xVal == 5'd27 ||
                                  xVal == 5'd29 || xVal == 5'd30)));
    isK28   = ctrlOk && (xVal == 5'd28);
    s6Neg   = isK28 ? 6'b001111 : sixNeg(xVal);
    flip6   = ($countones(s6Neg) != 3) || (xVal == 5'd7 && !isK28);
    s6      = (rdPos && flip6) ? ~s6Neg : s6Neg;
    rd6     = rdPos ^ ($countones(s6) != 3);
    useAlt  = 1'b0;
    s4Base  = 4'b0000;
    if (ctrlOk) begin
      s4 = rd6 ? fourCtrlPos(yVal) : ~fourCtrlPos(yVal);
    end else begin
      useAlt = (yVal == 3'd7) &&
               ((!rd6 && (xVal == 5'd17 || xVal == 5'd18 || xVal == 5'd20)) ||
                ( rd6 && (xVal == 5'd11 || xVal == 5'd13 || xVal == 5'd14)));
      s4Base = useAlt ? 4'b0111 : fourNeg(yVal);
      s4 = (rd6 && (($countones(s4Base) != 2) || yVal == 3'd3)) ? ~s4Base : s4Base;
    end
    rdNext = rd6 ^ ($countones(s4) != 2);
  end

  // place abcdei at bits 0..5 and fghj at bits 6..9
  for (genvar i = 0; i < 6; i++) begin : g_six
    assign encCode[i] = s6[5-i];
  end
  for (genvar i = 0; i < 4; i++) begin : g_four
    assign encCode[6+i] = s4[3-i];
  end

  always_ff @(posedge clk) begin
    if (strobe.idle) begin
      codeOut <= IDLE_CODE;
      rdPos   <= 1'b0;
      badCtrl <= 1'b0;
    end else begin
      codeOut <= encCode;
      rdPos   <= rdNext;
      badCtrl <= strobe.take && selCtrl && !ctrlOk;
    end
  end
endmodule

// File: rtl/linecode_enc.sv
module linecode_enc
  import linecode_pkg::*;
#(
  parameter int PREAMBLE_LEN = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] charIn,
  input  logic       isCtrl,
  output logic [9:0] codeOut,
  output logic       inReady,
  output logic       badCtrl
);
  encStrobe_t strobe;

  linecode_ctrl #(.PREAMBLE_LEN(PREAMBLE_LEN)) u_ctrl (
    .clk(clk), .rst(rst), .strobe(strobe), .inReady(inReady)
  );

  linecode_datapath u_dp (
    .clk(clk), .strobe(strobe), .charIn(charIn), .isCtrl(isCtrl),
    .codeOut(codeOut), .badCtrl(badCtrl)
  );
endmodule

// File: rtl/linecode_enc_chk.sv
module linecode_enc_chk (
  input logic       clk,
  input logic       rst,
  input logic [7:0] charIn,
  input logic       isCtrl,
  input logic [9:0] codeOut,
  input logic       inReady,
  input logic       badCtrl
);
  // R1
  idle_code_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (codeOut == 10'h17C && !badCtrl));

  // R2
  first_comma_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |=> (codeOut == 10'h17C && !inReady));

  // R6
  code_weight_chk: assert property (@(posedge clk) disable iff (rst)
    ($countones(codeOut) >= 4 && $countones(codeOut) <= 6));

  // R8
  bad_source_chk: assert property (@(posedge clk) disable iff (rst)
    badCtrl |-> $past(isCtrl && inReady));

  // R9
  data_no_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (inReady && !isCtrl) |=> !badCtrl);

  logic unusedChar;
  assign unusedChar = ^charIn;
endmodule

bind linecode_enc linecode_enc_chk u_chk (
  .clk(clk), .rst(rst), .charIn(charIn), .isCtrl(isCtrl),
  .codeOut(codeOut), .inReady(inReady), .badCtrl(badCtrl)
);

// File: tb/linecode_enc_tb.sv
module linecode_enc_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] charIn;
  logic       isCtrl;
  logic [9:0] codeOut;
  logic       inReady;
  logic       badCtrl;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  tbRd    = 1'b0;   // bench running disparity, 1 = positive
  bit  finished = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  linecode_enc u_dut (
    .clk(clk), .rst(rst), .charIn(charIn), .isCtrl(isCtrl),
    .codeOut(codeOut), .inReady(inReady), .badCtrl(badCtrl)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] tb6(input int x);
    logic [5:0] t [32] = '{6'b100111,6'b011101,6'b101101,6'b110001,6'b110101,6'b101001,
      6'b011001,6'b111000,6'b111001,6'b100101,6'b010101,6'b110100,6'b001101,6'b101100,
      6'b011100,6'b010111,6'b011011,6'b100011,6'b010011,6'b110010,6'b001011,6'b101010,
      6'b011010,6'b111010,6'b110011,6'b100110,6'b010110,6'b110110,6'b001110,6'b101110,
      6'b011110,6'b101011};
    return t[x];
  endfunction

  function automatic logic [3:0] tb4(input int y);
    logic [3:0] t [8] = '{4'b1011,4'b1001,4'b0101,4'b1100,4'b1101,4'b1010,4'b0110,4'b1110};
    return t[y];
  endfunction

  // K28.y fghj when running disparity before the group is negative
  function automatic logic [3:0] tbK28(input int y);
    logic [3:0] t [8] = '{4'b0100,4'b1001,4'b0101,4'b0011,4'b0010,4'b1010,4'b0110,4'b1000};
    return t[y];
  endfunction

  // decode a code group under running disparity rdIn
  task automatic decodeGroup(input logic [9:0] c, input bit rdIn, output bit ok,
                             output logic [7:0] b, output bit k, output bit alt,
                             output bit rdOut);
    logic [5:0] s6;
    logic [3:0] s4;
    int x, y, ones;
    bit k28, rd6;
    s6 = {c[0], c[1], c[2], c[3], c[4], c[5]};
    s4 = {c[6], c[7], c[8], c[9]};
    x = -1; y = -1; k = 0; alt = 0; k28 = 0; b = 8'h00; rdOut = rdIn;
    ones = $countones(c);
    ok = rdIn ? (ones == 4 || ones == 5) : (ones == 5 || ones == 6);
    if (s6 == (rdIn ? 6'b110000 : 6'b001111)) begin
      k28 = 1; x = 28;
    end else begin
      for (int xx = 0; xx < 32; xx++) begin
        logic [5:0] m;
        m = tb6(xx);
        if (((rdIn && ($countones(m) != 3 || xx == 7)) ? ~m : m) == s6) x = xx;
      end
    end
    rd6 = rdIn ^ ($countones(s6) != 3);
    if (k28) begin
      k = 1;
      for (int yy = 0; yy < 8; yy++)
        if ((rdIn ? ~tbK28(yy) : tbK28(yy)) == s4) y = yy;
    end else begin
      for (int yy = 0; yy < 8; yy++) begin
        logic [3:0] m;
        m = tb4(yy);
        if (((rd6 && ($countones(m) != 2 || yy == 3)) ? ~m : m) == s4) y = yy;
      end
      if (s4 == (rd6 ? 4'b1000 : 4'b0111)) begin
        y = 7; alt = 1;
        if (!(x == 17 || x == 18 || x == 20 || x == 11 || x == 13 || x == 14)) begin
          k = 1;
          if (!(x == 23 || x == 27 || x == 29 || x == 30)) ok = 0;
        end
      end
    end
    if (x < 0 || y < 0) ok = 0;
    else b = 8'((y << 5) | x);
    if (!k && y == 7) begin
      if (alt != ((!rd6 && (x == 17 || x == 18 || x == 20)) ||
                  (rd6 && (x == 11 || x == 13 || x == 14)))) ok = 0;
    end
    rdOut = rd6 ^ ($countones(s4) != 2);
  endtask

  // offer a byte on a ready cycle and judge the resulting code group
  task automatic sendChar(input logic [7:0] bIn, input bit kIn, input bit expBad,
                          input string req);
    bit ok, k, alt, rdOut;
    logic [7:0] b;
    check(inReady === 1'b1, {req, " ready"}, inReady, 1);
    charIn = bIn; isCtrl = kIn;
    @(posedge clk); @(negedge clk);
    decodeGroup(codeOut, tbRd, ok, b, k, alt, rdOut);
    check(ok, {req, " R5 R6 R7 code legal"}, codeOut, 0);
    check(b == bIn, {req, " byte"}, b, bIn);
    check(k == (kIn && !expBad), {req, " ctrl flag"}, k, kIn && !expBad);
    check(badCtrl == expBad, {req, " R8 badCtrl"}, badCtrl, expBad);
    tbRd = rdOut;
  endtask

  task automatic t_reset();
    rst = 1'b1; charIn = 8'hF7; isCtrl = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); @(negedge clk);
      check(codeOut == 10'h17C, "R1 idle code", codeOut, 10'h17C);
      check(inReady == 1'b0, "R1 ready low", inReady, 0);
      check(badCtrl == 1'b0, "R1 flag low", badCtrl, 0);
    end
  endtask

  task automatic t_preamble();
    logic [9:0] expSeq [3] = '{10'h17C, 10'h283, 10'h17C};
    rst = 1'b0; charIn = 8'hAA; isCtrl = 1'b0;
    tbRd = 1'b0;
    for (int i = 0; i < 3; i++) begin
      check(inReady == 1'b0, "R2 ready low in preamble", inReady, 0);
      @(posedge clk); @(negedge clk);
      check(codeOut == expSeq[i], "R2 preamble comma", codeOut, expSeq[i]);
      tbRd = ~tbRd;
    end
    sendChar(8'h55, 1'b0, 1'b0, "R2 R9 first user byte");
  endtask

  task automatic t_dataSweep();
    for (int i = 0; i < 256; i++) sendChar(8'(i), 1'b0, 1'b0, "R3 data");
    for (int i = 255; i >= 0; i--) sendChar(8'(i), 1'b0, 1'b0, "R3 data reverse");
  endtask

  task automatic t_ctrlValid();
    logic [7:0] ks [12] = '{8'h1C, 8'h3C, 8'h5C, 8'h7C, 8'h9C, 8'hBC, 8'hDC, 8'hFC,
                            8'hF7, 8'hFB, 8'hFD, 8'hFE};
    for (int r = 0; r < 2; r++)
      for (int i = 0; i < 12; i++) sendChar(ks[i], 1'b1, 1'b0, "R4 special");
  endtask

  task automatic t_ctrlBad();
    sendChar(8'h00, 1'b1, 1'b1, "R8 illegal special");
    sendChar(8'h21, 1'b0, 1'b0, "R8 flag clears");
    sendChar(8'hF1, 1'b1, 1'b1, "R8 illegal x.7 special");
    sendChar(8'h3D, 1'b1, 1'b1, "R8 illegal K29.1");
  endtask

  task automatic t_alt();
    logic [7:0] xs [6] = '{8'hF1, 8'hF2, 8'hF4, 8'hEB, 8'hED, 8'hEE};
    for (int i = 0; i < 6; i++) begin
      sendChar(xs[i], 1'b0, 1'b0, "R7 D.x.7");
      sendChar(8'h03, 1'b0, 1'b0, "R7 flip");
      sendChar(xs[i], 1'b0, 1'b0, "R7 D.x.7 other column");
    end
  endtask

  task automatic t_resetMid();
    sendChar(8'h12, 1'b0, 1'b0, "R10 before reset");
    check(inReady == 1'b1, "R10 ready before reset", inReady, 1);
    rst = 1'b1; charIn = 8'h3C; isCtrl = 1'b0;
    #1;
    check(inReady == 1'b0, "R10 ready drops with reset", inReady, 0);
    @(posedge clk); @(negedge clk);
    check(codeOut == 10'h17C, "R10 byte discarded", codeOut, 10'h17C);
    t_preamble();
    sendChar(8'h3C, 1'b0, 1'b0, "R10 traffic resumes");
  endtask

  initial begin
    rst = 1'b1; charIn = 8'h00; isCtrl = 1'b0;
    @(negedge clk);
    t_reset();
    t_preamble();
    t_dataSweep();
    t_ctrlValid();
    t_ctrlBad();
    t_alt();
    t_resetMid();
    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule